// File: doc/BRIEF.md
# Dual-Issue Pairing Checker

This block sits in the front end of a two-wide, in-order issue pipeline. Each cycle it looks at two adjacent instructions that a decoder has already classified. The first one (slot A) is older in program order and the second one (slot B) follows it directly. The block decides whether B may issue in the same cycle as A, or whether A must go out alone. It does not decode opcodes; the decoder supplies, for each slot:

- a class code;
- register indices;
- single-word and word-half marks for floating-point doubleword registers;
- carry/borrow set and use marks;
- FP load/store marks;
- a doubleword-pair mark.

The decoder also supplies position context: delay-slot placement of each slot, and whether A was reached as a taken-branch target at an odd word address.

The decision combines three sets of rules. The first is an asymmetric table of which class may follow which. The second is a set of operand hazards between the two slots. The third is a set of position rules. The single result, `pair_ok`, is registered. It is high only when every rule lets the pair through. When it is low, the issue stage sends only the first instruction that cycle.

Top module: `pair_checker`

## Requirements
- R1: While `rst` is high, `pair_ok` reads 0 at each following edge. Otherwise `pair_ok` holds the decision for the inputs present at the previous rising clock edge (one register of latency).
- R2: Class codes are flop=0, ldst=1, flex=2, mm=3, nul=4, bv=5, br=6, fsys=7 and sys=8. The allowed (A, B) pairs are the following, and every other combination is refused:
  - A=flop with B in {ldst, flex, mm, nul, bv, br};
  - A=ldst with B in {flop, flex, mm, nul, br};
  - A=flex with B in {flop, ldst, flex, mm, nul, br, fsys};
  - A=mm with B in {flop, ldst, flex, fsys};
  - A=nul with B=flop.
- R3: A sys instruction (code 8), or any code from 9 to 15, in either slot never pairs.
- R4: ldst followed by ldst pairs only when both `a_dw` and `b_dw` are 1.
- R5: The pair is refused when a nonzero `b_src0` or `b_src1` equals `a_dst`. Register index 0 never creates this dependency.
- R6: A match between `b_src1` (the store data operand) and `a_dst` is exempt from R5 when A is a flop and `b_fpst`=1. A match on `b_src0` is never exempt.
- R7: Take a slot with FP load (`fpld`=1) and single-word (`sw`=1), writing nonzero index R and word `hi`. It refuses pairing with a flop in the other slot whose source or target equals R, when that flop is full-width (`sw`=0) or its `hi` differs.
- R8: A flop and an FP load, in either order, whose nonzero targets are equal do not pair.
- R9: The pair is refused when one slot sets carry/borrow (`cset`) and the other uses it (`cuse`).
- R10: If either slot is in a branch delay slot (`a_dslot` or `b_dslot`), the pair is refused.
- R11: If A is a taken-branch target (`a_tgt`=1) at an odd word address (`a_odd`=1), the pair is refused. Either condition alone does not refuse.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| a_cls | input | 4 | Class code of slot A |
| a_src0 | input | REG_W | First source index of A |
| a_src1 | input | REG_W | Second source index of A |
| a_dst | input | REG_W | Target index of A (0 = none) |
| a_sw | input | 1 | A accesses a single word of a doubleword register |
| a_hi | input | 1 | Word half selected by A |
| a_cset | input | 1 | A may set carry/borrow |
| a_cuse | input | 1 | A reads carry/borrow |
| a_fpld | input | 1 | A is an FP load |
| a_dw | input | 1 | A is a half of a doubleword access pair |
| a_dslot | input | 1 | A sits in a branch delay slot |
| a_tgt | input | 1 | A reached as a taken-branch target |
| a_odd | input | 1 | A at an odd word address |
| b_cls | input | 4 | Class code of slot B |
| b_src0 | input | REG_W | First source (base) index of B |
| b_src1 | input | REG_W | Second source (store data) index of B |
| b_dst | input | REG_W | Target index of B (0 = none) |
| b_sw | input | 1 | B accesses a single word |
| b_hi | input | 1 | Word half selected by B |
| b_cset | input | 1 | B may set carry/borrow |
| b_cuse | input | 1 | B reads carry/borrow |
| b_fpld | input | 1 | B is an FP load |
| b_fpst | input | 1 | B is an FP store |
| b_dw | input | 1 | B is a half of a doubleword access pair |
| b_dslot | input | 1 | B sits in a branch delay slot |
| pair_ok | output | 1 | Registered: both slots may issue together |

## Verification
Every decision appears on `pair_ok` exactly one rising edge after its inputs are presented.

The bench changes the inputs on a falling edge and lets one rising edge pass. It then reads the output at the next falling edge, so each check lines up with exactly one input pattern.

The reset check holds legal inputs while reset is high. It then confirms that the first decision appears one edge after reset falls.

// File: rtl/pair_pkg.sv
package pair_pkg;

  localparam int CLS_W    = 4;
  localparam int NUM_CLS  = 2 ** CLS_W;
  localparam int NUM_SRC  = 2;
  localparam int DATA_SRC = 1;

  typedef enum logic [CLS_W-1:0] {
    CLS_FLOP = 4'd0,
    CLS_LDST = 4'd1,
    CLS_FLEX = 4'd2,
    CLS_MM   = 4'd3,
    CLS_NUL  = 4'd4,
    CLS_BV   = 4'd5,
    CLS_BR   = 4'd6,
    CLS_FSYS = 4'd7,
    CLS_SYS  = 4'd8
  } cls_e;

endpackage

// File: rtl/pair_class_matrix.sv
module pair_class_matrix
  import pair_pkg::*;
(
  input  logic [CLS_W-1:0] a_cls,
  input  logic [CLS_W-1:0] b_cls,
  input  logic             a_dw,
  input  logic             b_dw,
  output logic             cls_ok
);

  // Row of legal successors for a given leading class.
  function automatic logic [NUM_CLS-1:0] successors(input logic [CLS_W-1:0] lead,
                                                    input logic dw_pair);
    logic [NUM_CLS-1:0] m;
    m = '0;
    case (lead)
      CLS_FLOP: begin
        m[CLS_LDST] = 1'b1; m[CLS_FLEX] = 1'b1; m[CLS_MM] = 1'b1;
        m[CLS_NUL]  = 1'b1; m[CLS_BV]   = 1'b1; m[CLS_BR] = 1'b1;
      end
      CLS_LDST: begin
        m[CLS_FLOP] = 1'b1; m[CLS_FLEX] = 1'b1; m[CLS_MM] = 1'b1;
        m[CLS_NUL]  = 1'b1; m[CLS_BR]   = 1'b1;
        m[CLS_LDST] = dw_pair;
      end
      CLS_FLEX: begin
        m[CLS_FLOP] = 1'b1; m[CLS_LDST] = 1'b1; m[CLS_FLEX] = 1'b1;
        m[CLS_MM]   = 1'b1; m[CLS_NUL]  = 1'b1; m[CLS_BR]   = 1'b1;
        m[CLS_FSYS] = 1'b1;
      end
      CLS_MM: begin
        m[CLS_FLOP] = 1'b1; m[CLS_LDST] = 1'b1; m[CLS_FLEX] = 1'b1;
        m[CLS_FSYS] = 1'b1;
      end
      CLS_NUL: begin
        m[CLS_FLOP] = 1'b1;
      end
      default: m = '0;
    endcase
    return m;
  endfunction

  logic [NUM_CLS-1:0] row;

  always_comb begin
    row    = successors(a_cls, a_dw & b_dw);
    cls_ok = row[b_cls];
  end

endmodule

// File: rtl/pair_hazard_unit.sv
module pair_hazard_unit
  import pair_pkg::*;
#(
  parameter int REG_W = 5
) (
  input  logic [CLS_W-1:0]              a_cls,
  input  logic [NUM_SRC-1:0][REG_W-1:0] a_src,
  input  logic [REG_W-1:0]              a_dst,
  input  logic                          a_sw,
  input  logic                          a_hi,
  input  logic                          a_cset,
  input  logic                          a_cuse,
  input  logic                          a_fpld,
  input  logic [CLS_W-1:0]              b_cls,
  input  logic [NUM_SRC-1:0][REG_W-1:0] b_src,
  input  logic [REG_W-1:0]              b_dst,
  input  logic                          b_sw,
  input  logic                          b_hi,
  input  logic                          b_cset,
  input  logic                          b_cuse,
  input  logic                          b_fpld,
  input  logic                          b_fpst,
  output logic                          haz_ok
);

  localparam logic [REG_W-1:0] ZERO_REG = '0;

  logic a_flop, b_flop;
  logic [NUM_SRC-1:0] raw_hit, raw_exempt;
  logic [NUM_SRC-1:0] a_src_ref, b_src_ref;

  assign a_flop = (a_cls == CLS_FLOP);
  assign b_flop = (b_cls == CLS_FLOP);

  // Per-operand comparators: read-after-write into B, and operand
  // references used by the word-half rule.
  for (genvar g = 0; g < NUM_SRC; g++) begin : g_src
    assign raw_hit[g]    = (b_src[g] != ZERO_REG) && (b_src[g] == a_dst);
    assign raw_exempt[g] = (g == DATA_SRC) && a_flop && b_fpst;
    assign a_src_ref[g]  = (a_src[g] != ZERO_REG) && (a_src[g] == b_dst);
    assign b_src_ref[g]  = (b_src[g] != ZERO_REG) && (b_src[g] == a_dst);
  end

  logic raw_block;
  assign raw_block = |(raw_hit & ~raw_exempt);

  // Word-half clash: single-word FP load vs. flop touching the same register.
  logic half_ab, half_ba, half_block;
  logic a_refs_bdst, b_refs_adst;
  assign a_refs_bdst = (|a_src_ref) || ((a_dst != ZERO_REG) && (a_dst == b_dst));
  assign b_refs_adst = (|b_src_ref) || ((b_dst != ZERO_REG) && (b_dst == a_dst));

  assign half_ab = a_fpld && a_sw && (a_dst != ZERO_REG) && b_flop &&
                   b_refs_adst && (!b_sw || (b_hi != a_hi));
  assign half_ba = b_fpld && b_sw && (b_dst != ZERO_REG) && a_flop &&
                   a_refs_bdst && (!a_sw || (a_hi != b_hi));
  assign half_block = half_ab || half_ba;

  // Same target for a flop and an FP load, either order.
  logic same_tgt, tgt_block;
  assign same_tgt  = (a_dst != ZERO_REG) && (a_dst == b_dst);
  assign tgt_block = same_tgt && ((a_flop && b_fpld) || (a_fpld && b_flop));

  // Carry/borrow producer vs. consumer.
  logic carry_block;
  assign carry_block = (a_cset && b_cuse) || (b_cset && a_cuse);

  assign haz_ok = !(raw_block || half_block || tgt_block || carry_block);

endmodule

// File: rtl/pair_slot_rules.sv
module pair_slot_rules (
  input  logic a_dslot,
  input  logic b_dslot,
  input  logic a_tgt,
  input  logic a_odd,
  output logic slot_ok
);

  logic in_delay, odd_target;

  assign in_delay   = a_dslot | b_dslot;
  assign odd_target = a_tgt & a_odd;
  assign slot_ok    = ~(in_delay | odd_target);

endmodule

// File: rtl/pair_checker.sv
module pair_checker
  import pair_pkg::*;
#(
  parameter int REG_W = 5
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [3:0]       a_cls,
  input  logic [REG_W-1:0] a_src0,
  input  logic [REG_W-1:0] a_src1,
  input  logic [REG_W-1:0] a_dst,
  input  logic             a_sw,
  input  logic             a_hi,
  input  logic             a_cset,
  input  logic             a_cuse,
  input  logic             a_fpld,
  input  logic             a_dw,
  input  logic             a_dslot,
  input  logic             a_tgt,
  input  logic             a_odd,
  input  logic [3:0]       b_cls,
  input  logic [REG_W-1:0] b_src0,
  input  logic [REG_W-1:0] b_src1,
  input  logic [REG_W-1:0] b_dst,
  input  logic             b_sw,
  input  logic             b_hi,
  input  logic             b_cset,
  input  logic             b_cuse,
  input  logic             b_fpld,
  input  logic             b_fpst,
  input  logic             b_dw,
  input  logic             b_dslot,
  output logic             pair_ok
);

  logic cls_ok, haz_ok, slot_ok;
  logic [NUM_SRC-1:0][REG_W-1:0] a_src, b_src;

  assign a_src = {a_src1, a_src0};
  assign b_src = {b_src1, b_src0};

  pair_class_matrix u_matrix (
    .a_cls  (a_cls),
    .b_cls  (b_cls),
    .a_dw   (a_dw),
    .b_dw   (b_dw),
    .cls_ok (cls_ok)
  );

  pair_hazard_unit #(.REG_W(REG_W)) u_hazard (
    .a_cls  (a_cls),
    .a_src  (a_src),
    .a_dst  (a_dst),
    .a_sw   (a_sw),
    .a_hi   (a_hi),
    .a_cset (a_cset),
    .a_cuse (a_cuse),
    .a_fpld (a_fpld),
    .b_cls  (b_cls),
    .b_src  (b_src),
    .b_dst  (b_dst),
    .b_sw   (b_sw),
    .b_hi   (b_hi),
    .b_cset (b_cset),
    .b_cuse (b_cuse),
    .b_fpld (b_fpld),
    .b_fpst (b_fpst),
    .haz_ok (haz_ok)
  );

  pair_slot_rules u_slot (
    .a_dslot (a_dslot),
    .b_dslot (b_dslot),
    .a_tgt   (a_tgt),
    .a_odd   (a_odd),
    .slot_ok (slot_ok)
  );

  always_ff @(posedge clk) begin
    if (rst) pair_ok <= 1'b0;
    else     pair_ok <= cls_ok & haz_ok & slot_ok;
  end

  // R1: reset forces single issue.
  a_r1_reset_clears: assert property (@(posedge clk) rst |=> !pair_ok);

  // R3: a system-control instruction never shares its cycle.
  a_r3_sys_alone: assert property (@(posedge clk) disable iff (rst)
    ((a_cls == CLS_SYS) || (b_cls == CLS_SYS)) |=> !pair_ok);

  // R5: a base-operand dependency is never exempt.
  a_r5_base_raw: assert property (@(posedge clk) disable iff (rst)
    ((b_src0 != '0) && (b_src0 == a_dst)) |=> !pair_ok);

  // R9: carry/borrow producer and consumer stay apart.
  a_r9_carry_split: assert property (@(posedge clk) disable iff (rst)
    ((a_cset && b_cuse) || (b_cset && a_cuse)) |=> !pair_ok);

  // R10: delay-slot instructions issue alone.
  a_r10_delay_slot: assert property (@(posedge clk) disable iff (rst)
    (a_dslot || b_dslot) |=> !pair_ok);

  // R11: odd-address taken-branch target issues alone.
  a_r11_odd_target: assert property (@(posedge clk) disable iff (rst)
    (a_tgt && a_odd) |=> !pair_ok);

endmodule

// File: tb/pair_checker_bench.sv
module pair_checker_bench;

  localparam int REG_W = 5;

  logic clk = 1'b0;
  logic rst = 1'b1;
  always #10 clk = ~clk;

  logic [3:0]       a_cls, b_cls;
  logic [REG_W-1:0] a_src0, a_src1, a_dst, b_src0, b_src1, b_dst;
  logic a_sw, a_hi, a_cset, a_cuse, a_fpld, a_dw, a_dslot, a_tgt, a_odd;
  logic b_sw, b_hi, b_cset, b_cuse, b_fpld, b_fpst, b_dw, b_dslot;
  logic pair_ok;

  int n_checks = 0;
  int n_fail   = 0;
  bit done     = 1'b0;

  pair_checker #(.REG_W(REG_W)) u_pair_checker (
    .clk(clk), .rst(rst),
    .a_cls(a_cls), .a_src0(a_src0), .a_src1(a_src1), .a_dst(a_dst),
    .a_sw(a_sw), .a_hi(a_hi), .a_cset(a_cset), .a_cuse(a_cuse),
    .a_fpld(a_fpld), .a_dw(a_dw), .a_dslot(a_dslot), .a_tgt(a_tgt), .a_odd(a_odd),
    .b_cls(b_cls), .b_src0(b_src0), .b_src1(b_src1), .b_dst(b_dst),
    .b_sw(b_sw), .b_hi(b_hi), .b_cset(b_cset), .b_cuse(b_cuse),
    .b_fpld(b_fpld), .b_fpst(b_fpst), .b_dw(b_dw), .b_dslot(b_dslot),
    .pair_ok(pair_ok)
  );

  // Independent model of the pairing rules.
  function automatic bit follows_ok(int a, int b, bit dwp);
    case (a)
      0: return b inside {1, 2, 3, 4, 5, 6};
      1: return (b inside {0, 2, 3, 4, 6}) || (b == 1 && dwp);
      2: return b inside {0, 1, 2, 3, 4, 6, 7};
      3: return b inside {0, 1, 2, 7};
      4: return b == 0;
      default: return 1'b0;
    endcase
  endfunction

  function automatic bit touches(int r, int s0, int s1, int d);
    return r != 0 && (r == s0 || r == s1 || r == d);
  endfunction

  function automatic bit model();
    bit ok;
    int ad, bd;
    ad = int'(a_dst);
    bd = int'(b_dst);
    ok = follows_ok(int'(a_cls), int'(b_cls), a_dw && b_dw);
    if (b_src0 != 0 && int'(b_src0) == ad) ok = 0;
    if (b_src1 != 0 && int'(b_src1) == ad && !(a_cls == 0 && b_fpst)) ok = 0;
    if (a_fpld && a_sw && b_cls == 0 && touches(ad, b_src0, b_src1, bd) &&
        (!b_sw || b_hi != a_hi)) ok = 0;
    if (b_fpld && b_sw && a_cls == 0 && touches(bd, a_src0, a_src1, ad) &&
        (!a_sw || a_hi != b_hi)) ok = 0;
    if (ad != 0 && ad == bd && ((a_cls == 0 && b_fpld) || (b_cls == 0 && a_fpld))) ok = 0;
    if ((a_cset && b_cuse) || (b_cset && a_cuse)) ok = 0;
    if (a_dslot || b_dslot) ok = 0;
    if (a_tgt && a_odd) ok = 0;
    return ok;
  endfunction

  task automatic clear_inputs();
    {a_src0, a_src1, a_dst, b_src0, b_src1, b_dst} = '0;
    {a_sw, a_hi, a_cset, a_cuse, a_fpld, a_dw, a_dslot, a_tgt, a_odd} = '0;
    {b_sw, b_hi, b_cset, b_cuse, b_fpld, b_fpst, b_dw, b_dslot} = '0;
    a_cls = 4'd2;
    b_cls = 4'd2;
  endtask

  task automatic step();
    @(posedge clk);
    @(negedge clk);
  endtask

  task automatic chk(string tag, bit exp);
    n_checks++;
    if (pair_ok !== exp) begin
      n_fail++;
      $display("FAIL %s: pair_ok=%0b expected %0b (a_cls=%0d b_cls=%0d)",
               tag, pair_ok, exp, a_cls, b_cls);
    end
  endtask

  // Apply the current inputs, wait one edge, compare.
  task automatic run(string tag, bit exp);
    step();
    chk(tag, exp);
  endtask

  initial begin
    #(20 * 150000);
    if (!done) begin
      n_checks++;
      n_fail++;
      $display("FAIL watchdog: run hung, expected completion");
      $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
      $finish;
    end
  end

  initial begin
    bit [31:0] rs;
    clear_inputs();
    a_cls = 4'd0;
    @(negedge clk);
    step();
    chk("R1 in reset", 1'b0);
    step();
    chk("R1 in reset hold", 1'b0);
    rst = 1'b0;
    run("R1 first decision after reset", 1'b1);
    b_cls = 4'd8;
    run("R1 one-edge latency", 1'b0);

    // Class sweep with no hazards.
    for (int a = 0; a < 16; a++) begin
      for (int b = 0; b < 16; b++) begin
        clear_inputs();
        a_cls = 4'(a);
        b_cls = 4'(b);
        run((a > 7 || b > 7) ? "R3 sys/undefined" : "R2 class matrix",
            follows_ok(a, b, 1'b0));
      end
    end

    clear_inputs(); a_cls = 1; b_cls = 1; a_dw = 1; b_dw = 1;
    run("R4 ldst doubleword pair", 1'b1);
    b_dw = 0;
    run("R4 ldst without pair mark", 1'b0);

    clear_inputs(); a_dst = 3; b_src1 = 3;
    run("R5 raw on src1", 1'b0);
    clear_inputs(); a_dst = 0; b_src0 = 0; b_src1 = 0;
    run("R5 index zero free", 1'b1);

    clear_inputs(); a_cls = 0; a_dst = 4; b_cls = 1; b_fpst = 1; b_src1 = 4;
    run("R6 flop then store of result", 1'b1);
    b_src1 = 0; b_src0 = 4;
    run("R6 base match not exempt", 1'b0);

    clear_inputs(); a_cls = 0; a_src0 = 6; a_sw = 1; a_hi = 1;
    b_cls = 1; b_fpld = 1; b_sw = 1; b_hi = 0; b_dst = 6;
    run("R7 other half clash", 1'b0);
    b_hi = 1;
    run("R7 same half allowed", 1'b1);

    clear_inputs(); a_cls = 0; a_dst = 5; b_cls = 1; b_fpld = 1; b_dst = 5;
    run("R8 flop then load same target", 1'b0);
    clear_inputs(); a_cls = 1; a_fpld = 1; a_dst = 5; b_cls = 0; b_dst = 5;
    run("R8 load then flop same target", 1'b0);
    b_dst = 7;
    run("R8 distinct targets", 1'b1);

    clear_inputs(); a_cset = 1; b_cuse = 1;
    run("R9 set then use", 1'b0);
    clear_inputs(); b_cset = 1; a_cuse = 1;
    run("R9 use then set", 1'b0);
    clear_inputs(); a_cset = 1; b_cset = 1;
    run("R9 both set only", 1'b1);

    clear_inputs(); a_dslot = 1;
    run("R10 first in delay slot", 1'b0);
    clear_inputs(); b_dslot = 1;
    run("R10 second in delay slot", 1'b0);

    clear_inputs(); a_tgt = 1; a_odd = 1;
    run("R11 odd taken target", 1'b0);
    a_odd = 0;
    run("R11 even target", 1'b1);
    a_tgt = 0; a_odd = 1;
    run("R11 odd, not target", 1'b1);

    // Pseudo-random sweep over a small register range.
    rs = 32'h1234_5679;
    for (int i = 0; i < 3000; i++) begin
      rs ^= rs << 13; rs ^= rs >> 17; rs ^= rs << 5;
      a_cls  = (rs[3:0] > 9) ? 4'(rs[3:0] - 7) : rs[3:0];
      b_cls  = (rs[7:4] > 9) ? 4'(rs[7:4] - 7) : rs[7:4];
      a_src0 = REG_W'(rs[9:8]);   a_src1 = REG_W'(rs[11:10]); a_dst = REG_W'(rs[13:12]);
      b_src0 = REG_W'(rs[15:14]); b_src1 = REG_W'(rs[17:16]); b_dst = REG_W'(rs[19:18]);
      a_sw = rs[20]; a_hi = rs[21]; b_sw = rs[22]; b_hi = rs[23];
      a_fpld = rs[24]; b_fpld = rs[25]; b_fpst = rs[26];
      a_dw = rs[27]; b_dw = rs[28];
      a_cset = rs[29] & rs[30]; a_cuse = rs[31] & rs[0];
      b_cset = rs[1] & rs[2];   b_cuse = rs[3] & rs[5];
      a_dslot = rs[6] & rs[7] & rs[8];
      b_dslot = rs[9] & rs[10] & rs[11];
      a_tgt = rs[12] & rs[13]; a_odd = rs[14];
      run("R2 R5 R7 R8 random model", model());
    end

    done = 1'b1;
    $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
    $finish;
  end

endmodule